// File: doc/BRIEF.md
# Byte-Coded Stack Machine Core

This block is a multi-cycle execution engine for a compact byte-coded stack language. Opcodes and their operand bytes come in through a byte-wide fetch port addressed by the program counter. Stack slots and local variables are 32-bit words reached through a separate word-wide port, addressed by word index. The value on top of the stack is kept in a register, so most operations need at most one memory read and one memory write.

Both ports use the same handshake. The core raises a request and holds the address, and the write data when there is any, until the memory answers with a one-cycle valid. Branch offsets are 16 bits. The high byte is signed and the low byte is unsigned, and the offset is added to the address of the branch opcode itself. The core stops on a halt opcode. On an unrecognised opcode it stops and raises a sticky error flag. A print opcode sends one byte to a character strobe output.

Top module: `stk_core`

## Requirements
- R1: After reset the PC is 0, the local-variable base is 1024, SP is 1023 and TOS is 0. The halted, illegal and character-valid outputs are all low.
- R2: The PC advances by one for each opcode or operand byte fetched. NOP (0x00) changes nothing else.
- R3: PUSHB (0x10) fetches one byte and sign-extends it from bit 7. It increments SP, writes the value at SP and loads it into TOS.
- R4: ADD (0x60), SUB (0x64), AND (0x7E) and OR (0x80) decrement SP and read the word at the new SP (the lower operand). They combine it with the old TOS, and SUB computes lower minus old TOS. The result, wrapped modulo 2^32, goes to TOS and is written at SP.
- R5: DROP (0x57) decrements SP and reloads TOS from the word at the new SP. DUP (0x59) increments SP and writes TOS there. SP never moves by more than one in a cycle.
- R6: SWAP (0x5F) exchanges the words at SP-1 and SP. TOS takes the old value from SP-1, and SP is unchanged.
- R7: LDLOC (0x15) and STLOC (0x36) fetch an unsigned index byte and access word base+index. LDLOC pushes that word. STLOC stores TOS there and then pops: SP decrements and TOS is reloaded from memory.
- R8: INCLOC (0x84) fetches an unsigned index byte and then a signed constant byte. It adds the constant to the local word at base+index.
- R9: JMP (0xA7) fetches a signed high byte and an unsigned low byte. The new PC is the opcode's own address plus the 16-bit offset they form, so backward jumps are possible.
- R10: JZ (0x99) and JNEG (0x9B) pop the stack and test the popped value for zero or for a set bit 31. If the test holds they branch like JMP. Otherwise execution continues at the opcode address plus 3.
- R11: PUTC (0x23) fetches one byte and pulses the character-valid output high for exactly one cycle with that byte on the character output.
- R12: HALT (0x2F) stops execution for good. The halted output stays high, no further fetches are made and the PC holds.
- R13: Any other opcode (for example 0x13) stops execution with the illegal output held high and no further fetches. The PC stays one past the bad opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_req_o | output | 1 | Byte fetch request |
| fetch_addr_o | output | 32 | Byte address (PC) |
| fetch_valid_i | input | 1 | Fetch data valid |
| fetch_data_i | input | 8 | Fetched byte |
| mem_req_o | output | 1 | Word access request |
| mem_we_o | output | 1 | Word access is a write |
| mem_addr_o | output | 32 | Word index |
| mem_wdata_o | output | 32 | Write data |
| mem_valid_i | input | 1 | Word access complete / read data valid |
| mem_rdata_i | input | 32 | Read data |
| char_valid_o | output | 1 | Character strobe |
| char_o | output | 8 | Character byte |
| halted_o | output | 1 | Execution stopped by HALT |
| illegal_o | output | 1 | Execution stopped by an unknown opcode |
| pc_o | output | 32 | Program counter |
| sp_o | output | 32 | Stack pointer (word index) |
| tos_o | output | 32 | Cached top-of-stack value |

## Verification
The hardest case to reach is the conditional branches. They pop and reload TOS from memory before the offset bytes are fetched, yet they must test the value that was popped. If the stale value were tested instead, nothing would show unless the word below differs in its zero or sign status. The stimulus therefore runs a value sweep from -2 to 2 through both conditions on a stack whose lower word is always 0, so that taken and not-taken runs end at different halt addresses. Backward jumps are driven by a negative high offset byte that lands on code before the jump.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [7:0] {
    OP_NOP    = 8'h00,
    OP_PUSHB  = 8'h10,
    OP_LDLOC  = 8'h15,
    OP_PUTC   = 8'h23,
    OP_HALT   = 8'h2F,
    OP_STLOC  = 8'h36,
    OP_DROP   = 8'h57,
    OP_DUP    = 8'h59,
    OP_SWAP   = 8'h5F,
    OP_ADD    = 8'h60,
    OP_SUB    = 8'h64,
    OP_AND    = 8'h7E,
    OP_OR     = 8'h80,
    OP_INCLOC = 8'h84,
    OP_JZ     = 8'h99,
    OP_JNEG   = 8'h9B,
    OP_JMP    = 8'hA7
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_OPND_A, ST_OPND_B,
    ST_READ, ST_WRITE, ST_WRITE2, ST_HALT, ST_ERR
  } state_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e         op_i,
  input  logic [DW-1:0]   below_i,
  input  logic [DW-1:0]   top_i,
  output logic [DW-1:0]   res_o
);
  always_comb begin
    case (op_i)
      ALU_SUB: res_o = below_i - top_i;
      ALU_AND: res_o = below_i & top_i;
      ALU_OR:  res_o = below_i | top_i;
      default: res_o = below_i + top_i;
    endcase
  end
endmodule

// File: rtl/stk_branch.sv
module stk_branch
  import stk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [7:0]      op_i,
  input  logic [DW-1:0]   base_i,
  input  logic [7:0]      hi_i,
  input  logic [7:0]      lo_i,
  input  logic [DW-1:0]   cond_i,
  output logic [DW-1:0]   target_o,
  output logic            take_o
);
  localparam int EXT = DW - 16;

  assign target_o = base_i + {{EXT{hi_i[7]}}, hi_i, lo_i};

  always_comb begin
    case (op_i)
      OP_JMP:  take_o = 1'b1;
      OP_JZ:   take_o = (cond_i == '0);
      OP_JNEG: take_o = cond_i[DW-1];
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int DW      = 32,
  parameter int LV_BASE = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          fetch_req_o,
  output logic [DW-1:0] fetch_addr_o,
  input  logic          fetch_valid_i,
  input  logic [7:0]    fetch_data_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          char_valid_o,
  output logic [7:0]    char_o,
  output logic          halted_o,
  output logic          illegal_o,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] tos_o
);
  localparam logic [DW-1:0] LV      = DW'(LV_BASE);
  localparam logic [DW-1:0] SP_INIT = DW'(LV_BASE - 1);

  state_e        state_q;
  logic [7:0]    ir_q, hi_q, char_q;
  logic [DW-1:0] pc_q, sp_q, tos_q, h_q, opc_q, mar_q, mdr_q;
  logic          char_valid_q;

  logic [DW-1:0] sp_inc, sp_dec, byte_sext, byte_zext, alu_res, br_target;
  logic          br_take;
  alu_op_e       alu_op;

  assign sp_inc    = sp_q + 1'b1;
  assign sp_dec    = sp_q - 1'b1;
  assign byte_sext = {{(DW-8){fetch_data_i[7]}}, fetch_data_i};
  assign byte_zext = {{(DW-8){1'b0}}, fetch_data_i};

  always_comb begin
    case (ir_q)
      OP_SUB:  alu_op = ALU_SUB;
      OP_AND:  alu_op = ALU_AND;
      OP_OR:   alu_op = ALU_OR;
      default: alu_op = ALU_ADD;
    endcase
  end

  stk_alu #(.DW(DW)) u_alu (
    .op_i(alu_op), .below_i(mem_rdata_i), .top_i(h_q), .res_o(alu_res)
  );

  stk_branch #(.DW(DW)) u_branch (
    .op_i(ir_q), .base_i(opc_q), .hi_i(hi_q), .lo_i(fetch_data_i),
    .cond_i(h_q), .target_o(br_target), .take_o(br_take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_FETCH;
      ir_q         <= '0;
      hi_q         <= '0;
      pc_q         <= '0;
      sp_q         <= SP_INIT;
      tos_q        <= '0;
      h_q          <= '0;
      opc_q        <= '0;
      mar_q        <= '0;
      mdr_q        <= '0;
      char_valid_q <= 1'b0;
      char_q       <= '0;
    end else begin
      char_valid_q <= 1'b0;
      case (state_q)
        ST_FETCH: if (fetch_valid_i) begin
          ir_q    <= fetch_data_i;
          opc_q   <= pc_q;
          pc_q    <= pc_q + 1'b1;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          case (ir_q)
            OP_NOP: state_q <= ST_FETCH;
            OP_PUSHB, OP_LDLOC, OP_STLOC, OP_INCLOC, OP_PUTC, OP_JMP:
              state_q <= ST_OPND_A;
            OP_JZ, OP_JNEG, OP_ADD, OP_SUB, OP_AND, OP_OR: begin
              h_q     <= tos_q;   // popped value / upper operand
              sp_q    <= sp_dec;
              mar_q   <= sp_dec;
              state_q <= ST_READ;
            end
            OP_DROP: begin
              sp_q    <= sp_dec;
              mar_q   <= sp_dec;
              state_q <= ST_READ;
            end
            OP_DUP: begin
              sp_q    <= sp_inc;
              mar_q   <= sp_inc;
              mdr_q   <= tos_q;
              state_q <= ST_WRITE;
            end
            OP_SWAP: begin
              mar_q   <= sp_dec;
              state_q <= ST_READ;
            end
            OP_HALT: state_q <= ST_HALT;
            default: state_q <= ST_ERR;
          endcase
        end
        ST_OPND_A: if (fetch_valid_i) begin
          pc_q <= pc_q + 1'b1;
          case (ir_q)
            OP_PUSHB: begin
              sp_q    <= sp_inc;
              mar_q   <= sp_inc;
              mdr_q   <= byte_sext;
              tos_q   <= byte_sext;
              state_q <= ST_WRITE;
            end
            OP_LDLOC, OP_INCLOC: begin
              mar_q   <= LV + byte_zext;
              state_q <= ST_READ;
            end
            OP_STLOC: begin
              mar_q   <= LV + byte_zext;
              mdr_q   <= tos_q;
              state_q <= ST_WRITE;
            end
            OP_PUTC: begin
              char_valid_q <= 1'b1;
              char_q       <= fetch_data_i;
              state_q      <= ST_FETCH;
            end
            default: begin
              hi_q    <= fetch_data_i;
              state_q <= ST_OPND_B;
            end
          endcase
        end
        ST_OPND_B: if (fetch_valid_i) begin
          if (ir_q == OP_INCLOC) begin
            pc_q    <= pc_q + 1'b1;
            mdr_q   <= mdr_q + byte_sext;
            state_q <= ST_WRITE;
          end else begin
            pc_q    <= br_take ? br_target : pc_q + 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_READ: if (mem_valid_i) begin
          case (ir_q)
            OP_DROP, OP_STLOC: begin
              tos_q   <= mem_rdata_i;
              state_q <= ST_FETCH;
            end
            OP_JZ, OP_JNEG: begin
              tos_q   <= mem_rdata_i;
              state_q <= ST_OPND_A;
            end
            OP_LDLOC: begin
              tos_q   <= mem_rdata_i;
              mdr_q   <= mem_rdata_i;
              sp_q    <= sp_inc;
              mar_q   <= sp_inc;
              state_q <= ST_WRITE;
            end
            OP_INCLOC: begin
              mdr_q   <= mem_rdata_i;
              state_q <= ST_OPND_B;
            end
            OP_SWAP: begin
              h_q     <= mem_rdata_i;
              mdr_q   <= mem_rdata_i;
              mar_q   <= sp_q;
              state_q <= ST_WRITE;
            end
            default: begin
              tos_q   <= alu_res;
              mdr_q   <= alu_res;
              state_q <= ST_WRITE;
            end
          endcase
        end
        ST_WRITE: if (mem_valid_i) begin
          case (ir_q)
            OP_STLOC: begin
              sp_q    <= sp_dec;
              mar_q   <= sp_dec;
              state_q <= ST_READ;
            end
            OP_SWAP: begin
              mar_q   <= sp_dec;
              mdr_q   <= tos_q;
              tos_q   <= h_q;
              state_q <= ST_WRITE2;
            end
            default: state_q <= ST_FETCH;
          endcase
        end
        ST_WRITE2: if (mem_valid_i) state_q <= ST_FETCH;
        default: state_q <= state_q;
      endcase
    end
  end

  assign fetch_req_o  = (state_q == ST_FETCH) || (state_q == ST_OPND_A) || (state_q == ST_OPND_B);
  assign fetch_addr_o = pc_q;
  assign mem_req_o    = (state_q == ST_READ) || (state_q == ST_WRITE) || (state_q == ST_WRITE2);
  assign mem_we_o     = (state_q == ST_WRITE) || (state_q == ST_WRITE2);
  assign mem_addr_o   = mar_q;
  assign mem_wdata_o  = mdr_q;
  assign char_valid_o = char_valid_q;
  assign char_o       = char_q;
  assign halted_o     = (state_q == ST_HALT);
  assign illegal_o    = (state_q == ST_ERR);
  assign pc_o         = pc_q;
  assign sp_o         = sp_q;
  assign tos_o        = tos_q;

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && fetch_valid_i) |=> (pc_q == $past(pc_q) + 1'b1));

  assert_sp_single_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_q != $past(sp_q)) |-> (sp_q == $past(sp_q) + 1'b1 || sp_q == $past(sp_q) - 1'b1));

  assert_char_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |=> !char_valid_o);

  assert_halt_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && !fetch_req_o && $stable(pc_q)));

  assert_illegal_sticky_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> (illegal_o && !fetch_req_o && !mem_req_o));
endmodule

// File: tb/stk_core_tb.sv
module stk_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req, fetch_valid, mem_req, mem_we, mem_valid;
  logic [31:0] fetch_addr, mem_addr, mem_wdata, mem_rdata, pc, sp, tos;
  logic [7:0]  fetch_data, ch;
  logic        ch_valid, halted, illegal;
  logic        clr = 1'b0;

  logic [7:0]  prog [0:255];
  logic [31:0] dmem [0:2047];

  int n_chk = 0, n_err = 0, cyc_all = 0, char_cnt = 0;
  logic [7:0] last_char;

  always #5 clk = ~clk;

  stk_core u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_o(fetch_req), .fetch_addr_o(fetch_addr),
    .fetch_valid_i(fetch_valid), .fetch_data_i(fetch_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata),
    .char_valid_o(ch_valid), .char_o(ch), .halted_o(halted), .illegal_o(illegal),
    .pc_o(pc), .sp_o(sp), .tos_o(tos)
  );

  // memory model: one wait cycle per access
  always @(posedge clk) begin
    if (clr) for (int i = 0; i < 2048; i++) dmem[i] <= '0;
    if (!rst_n) begin
      fetch_valid <= 1'b0;
      mem_valid   <= 1'b0;
    end else begin
      if (fetch_req && !fetch_valid) begin
        fetch_valid <= 1'b1;
        fetch_data  <= prog[fetch_addr[7:0]];
      end else fetch_valid <= 1'b0;
      if (mem_req && !mem_valid) begin
        mem_valid <= 1'b1;
        if (mem_we) dmem[mem_addr[10:0]] <= mem_wdata;
        else mem_rdata <= dmem[mem_addr[10:0]];
      end else mem_valid <= 1'b0;
    end
  end

  always @(negedge clk) if (rst_n && ch_valid) begin
    char_cnt  = char_cnt + 1;
    last_char = ch;
  end

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      n_err++;
      $display("FAIL R12 watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 8'h00;
  endtask

  task automatic setb(int a, int v);
    prog[a] = v[7:0];
  endtask

  task automatic run();
    @(negedge clk);
    rst_n = 1'b0;
    clr = 1'b1;
    char_cnt = 0;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 3000 && !halted && !illegal; c++) @(negedge clk);
  endtask

  initial begin
    int vals [6] = '{-128, -1, 0, 1, 5, 127};
    int cv [5] = '{-2, -1, 0, 1, 2};
    logic [31:0] e;
    int idle;

    clear_prog();
    repeat (3) @(negedge clk);
    chk("R1 pc", pc, 32'd0);
    chk("R1 sp", sp, 32'd1023);
    chk("R1 tos", tos, 32'd0);
    chk("R1 flags", {29'd0, halted, illegal, ch_valid}, 32'd0);

    // R2: NOP only advances PC
    clear_prog(); setb(0, 8'h00); setb(1, 8'h00); setb(2, 8'h2F);
    run();
    chk("R2 pc after nops", pc, 32'd3);
    chk("R2 sp unchanged", sp, 32'd1023);

    // R4 sweep over operand pairs and all four ops (R3 push pattern)
    for (int op = 0; op < 4; op++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          logic [7:0] opc;
          case (op)
            0: begin opc = 8'h60; e = vals[i] + vals[j]; end
            1: begin opc = 8'h64; e = vals[i] - vals[j]; end
            2: begin opc = 8'h7E; e = vals[i] & vals[j]; end
            default: begin opc = 8'h80; e = vals[i] | vals[j]; end
          endcase
          clear_prog();
          setb(0, 8'h10); setb(1, vals[i]); setb(2, 8'h10); setb(3, vals[j]);
          setb(4, opc); setb(5, 8'h2F);
          run();
          chk("R4 tos", tos, e);
          chk("R4 mem", dmem[1024], e);
          chk("R4 sp", sp, 32'd1024);
        end
      end
    end

    // R3 sign extension
    clear_prog(); setb(0, 8'h10); setb(1, 8'h80); setb(2, 8'h2F);
    run();
    chk("R3 tos", tos, 32'hFFFF_FF80);
    chk("R3 mem", dmem[1024], 32'hFFFF_FF80);
    chk("R3 sp", sp, 32'd1024);

    // R5 drop
    clear_prog(); setb(0, 8'h10); setb(1, 3); setb(2, 8'h10); setb(3, 9);
    setb(4, 8'h57); setb(5, 8'h2F);
    run();
    chk("R5 drop tos", tos, 32'd3);
    chk("R5 drop sp", sp, 32'd1024);
    // R5 dup
    clear_prog(); setb(0, 8'h10); setb(1, 8'hFB); setb(2, 8'h59); setb(3, 8'h2F);
    run();
    chk("R5 dup sp", sp, 32'd1025);
    chk("R5 dup mem", dmem[1025], 32'hFFFF_FFFB);
    chk("R5 dup tos", tos, 32'hFFFF_FFFB);

    // R6 swap
    clear_prog(); setb(0, 8'h10); setb(1, 1); setb(2, 8'h10); setb(3, 2);
    setb(4, 8'h5F); setb(5, 8'h2F);
    run();
    chk("R6 lower", dmem[1024], 32'd2);
    chk("R6 upper", dmem[1025], 32'd1);
    chk("R6 tos", tos, 32'd1);
    chk("R6 sp", sp, 32'd1025);

    // R7 store to index 200 then load it back
    clear_prog(); setb(0, 8'h10); setb(1, 42); setb(2, 8'h36); setb(3, 200);
    setb(4, 8'h2F);
    run();
    chk("R7 store mem", dmem[1224], 32'd42);
    chk("R7 store sp", sp, 32'd1023);
    chk("R7 store tos", tos, 32'd0);
    clear_prog(); setb(0, 8'h10); setb(1, 42); setb(2, 8'h36); setb(3, 200);
    setb(4, 8'h15); setb(5, 200); setb(6, 8'h2F);
    run();
    chk("R7 load tos", tos, 32'd42);
    chk("R7 load sp", sp, 32'd1024);

    // R8 local increment by negative constants
    clear_prog(); setb(0, 8'h10); setb(1, 10); setb(2, 8'h36); setb(3, 5);
    setb(4, 8'h84); setb(5, 5); setb(6, 8'hFD);
    setb(7, 8'h84); setb(8, 5); setb(9, 8'h80); setb(10, 8'h2F);
    run();
    chk("R8 local", dmem[1029], 32'hFFFF_FF87);
    chk("R8 pc", pc, 32'd11);

    // R9 forward jump
    clear_prog(); setb(0, 8'hA7); setb(1, 0); setb(2, 5); setb(3, 8'h2F);
    setb(5, 8'h10); setb(6, 1); setb(7, 8'h2F);
    run();
    chk("R9 fwd tos", tos, 32'd1);
    chk("R9 fwd pc", pc, 32'd8);
    // R9 backward jump
    clear_prog(); setb(0, 8'hA7); setb(1, 0); setb(2, 6); setb(3, 8'h10);
    setb(4, 9); setb(5, 8'h2F); setb(6, 8'hA7); setb(7, 8'hFF); setb(8, 8'hFD);
    run();
    chk("R9 back tos", tos, 32'd9);
    chk("R9 back pc", pc, 32'd6);

    // R10 conditional sweep
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 5; i++) begin
        bit take;
        take = (k == 0) ? (cv[i] == 0) : (cv[i] < 0);
        clear_prog(); setb(0, 8'h10); setb(1, cv[i]);
        setb(2, (k == 0) ? 8'h99 : 8'h9B); setb(3, 0); setb(4, 5);
        setb(5, 8'h2F); setb(7, 8'h2F);
        run();
        chk("R10 pc", pc, take ? 32'd8 : 32'd6);
        chk("R10 sp", sp, 32'd1023);
        chk("R10 tos", tos, 32'd0);
      end
    end

    // R11 character output
    clear_prog(); setb(0, 8'h23); setb(1, 8'hC8); setb(2, 8'h2F);
    run();
    chk("R11 count", char_cnt, 32'd1);
    chk("R11 byte", {24'd0, last_char}, 32'h0000_00C8);

    // R12 halted stays idle
    idle = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (fetch_req || !halted) idle++;
    end
    chk("R12 idle", idle, 32'd0);
    chk("R12 pc", pc, 32'd3);

    // R13 unknown opcode
    clear_prog(); setb(0, 8'h13); setb(1, 8'h2F);
    run();
    repeat (5) @(negedge clk);
    chk("R13 illegal", {31'd0, illegal}, 32'd1);
    chk("R13 halted", {31'd0, halted}, 32'd0);
    chk("R13 pc", pc, 32'd1);
    chk("R13 no fetch", {31'd0, fetch_req}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule